// File: doc/BRIEF.md
# Reference Divider with Frequency Steering

This block divides a reference clock by a programmable value R and produces a one-cycle marker pulse, fR, once per division period. It compares the fR marker with the rising edges of an externally divided VCO signal, fV, which arrives on `fv_i`. From that comparison it produces three indications. The first is a charge-window flag, which is high from each fR edge until the next fV edge. The second is a steering output that can be placed in high impedance. It asserts its enable when one side produces two edges in a row with no edge from the other side between them, and its value shows which side is fast. The third is a lock flag, which drops for exactly the cycles in which a steering pulse is driven.

In a loop, the steering pulses repeat at about the difference between the two divided frequencies. The pad driver forms the three-state pin from `steer_oe_o` and `steer_drv_o`. The analog ramp, the sample-and-hold and the analog phase output are outside this block.

An "fR event" is a rising clock edge at which `fr_o` is high. An "fV event" is a rising clock edge at which `fv_i` is high and was low at the previous rising edge. After reset, the previous value of `fv_i` is taken as low. All outputs are registered. Each output reflects the events of one rising edge from the following rising edge onward.

Top module: `refdiv_steer`

## Requirements
- R1: For a divide value R in 3..16383, `fr_o` is a one-cycle high pulse, and consecutive pulses are exactly R clock cycles apart.
- R2: A divide value of 0, 1 or 2 behaves as R = 3, so the pulses are 3 cycles apart.
- R3: An fR event with no fV event sets `charge_o` high from the next cycle. An fV event clears it from the next cycle. Otherwise it holds its value.
- R4: When an fR event and an fV event fall on the same edge, `charge_o` is low from the next cycle, which is a zero-length window. No steering pulse results, and neither edge counts as the first of a pair.
- R5: An fR event that follows an earlier fR event, with no fV event in between, gives one cycle of `steer_oe_o` = 1 with `steer_drv_o` = 1 (VCO slow) in the next cycle.
- R6: An fV event that follows an earlier fV event, with no fR event in between, gives one cycle of `steer_oe_o` = 1 with `steer_drv_o` = 0 (VCO fast) in the next cycle.
- R7: In every other cycle `steer_oe_o` is 0, which puts the steering pin in high impedance. A steering pulse never lasts more than one cycle.
- R8: `lock_o` is 0 in exactly the cycles where `steer_oe_o` is 1, and 1 in all other cycles.
- R9: While `rst_ni` is low: `fr_o` = 0, `charge_o` = 0, `steer_oe_o` = 0, `lock_o` = 1.
- R10: An fV event needs a low-to-high change of `fv_i`. If `fv_i` is held high, it counts as one event only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_r_i | input | 14 | Latched reference divide value R |
| fv_i | input | 1 | Divided VCO signal; its rising edges are fV events |
| fr_o | output | 1 | Divided reference marker pulse |
| charge_o | output | 1 | Charge window, high from fR to fV |
| steer_oe_o | output | 1 | Steering pin drive enable; 0 means high impedance |
| steer_drv_o | output | 1 | Steering level while enabled: 1 means VCO slow, 0 means VCO fast |
| lock_o | output | 1 | Lock flag; low during steering pulses |

## Verification
The assertions assume that `fv_i` is synchronous to `clk_i` and stays stable around each rising edge. They also rely on the minimum spacing between events: fV events are at least two cycles apart, and the 3-cycle floor on R keeps fR events at least three cycles apart. Together these make a one-cycle steering pulse always return low.

The stimulus changes `fv_i` only one nanosecond after a rising edge. It holds `div_r_i` constant for the whole run of each configuration. It sweeps small R values, including the clamped ones, against a quiet fV, fV pulse trains both slower and faster than fR, an fV that mirrors fR on the same edge, and a held-high fV. It also makes one long run at the largest R.

// File: rtl/refsteer_pkg.sv
`timescale 1ns/1ps
package refsteer_pkg;
  localparam int unsigned R_MIN = 3;

  typedef enum logic [1:0] {
    LAST_NONE = 2'd0,
    LAST_FR   = 2'd1,
    LAST_FV   = 2'd2
  } last_e;
endpackage

// File: rtl/ref_div.sv
`timescale 1ns/1ps
module ref_div #(
  parameter int unsigned RW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] div_r_i,
  output logic          fr_o
);
  import refsteer_pkg::*;

  localparam logic [RW-1:0] R_FLOOR = RW'(R_MIN);

  logic [RW-1:0] r_eff;
  logic [RW-1:0] cnt_q;
  logic          wrap;
  logic          fr_q;

  assign r_eff = (div_r_i < R_FLOOR) ? R_FLOOR : div_r_i;
  // >= so a shrinking R wraps at once instead of running to overflow
  assign wrap  = (cnt_q >= (r_eff - RW'(1)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      fr_q  <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + RW'(1);
      fr_q  <= wrap;
    end
  end

  assign fr_o = fr_q;

  p_fr_width_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_q |=> !fr_q);
  p_fr_floor_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_q && !$past(fr_q)) |=> (!fr_q ##1 !fr_q));
endmodule

// File: rtl/edge_rise.sv
`timescale 1ns/1ps
module edge_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  logic d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) d_q <= 1'b0;
    else         d_q <= sig_i;
  end

  assign rise_o = sig_i & ~d_q;

  p_rise_once_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/steer_ctrl.sv
`timescale 1ns/1ps
module steer_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fr_ev_i,
  input  logic fv_ev_i,
  output logic charge_o,
  output logic steer_oe_o,
  output logic steer_drv_o,
  output logic lock_o
);
  import refsteer_pkg::*;

  last_e last_q, last_d;
  logic  charge_q, charge_d;
  logic  oe_q, oe_d;
  logic  drv_q, drv_d;
  logic  lock_q;

  always_comb begin
    last_d   = last_q;
    charge_d = charge_q;
    oe_d     = 1'b0;
    drv_d    = 1'b0;
    unique case ({fr_ev_i, fv_ev_i})
      2'b11: begin
        last_d   = LAST_NONE;
        charge_d = 1'b0;
      end
      2'b10: begin
        if (last_q == LAST_FR) begin
          oe_d  = 1'b1;
          drv_d = 1'b1;
        end
        last_d   = LAST_FR;
        charge_d = 1'b1;
      end
      2'b01: begin
        if (last_q == LAST_FV) begin
          oe_d  = 1'b1;
          drv_d = 1'b0;
        end
        last_d   = LAST_FV;
        charge_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q   <= LAST_NONE;
      charge_q <= 1'b0;
      oe_q     <= 1'b0;
      drv_q    <= 1'b0;
      lock_q   <= 1'b1;
    end else begin
      last_q   <= last_d;
      charge_q <= charge_d;
      oe_q     <= oe_d;
      drv_q    <= drv_d;
      lock_q   <= ~oe_d;
    end
  end

  assign charge_o    = charge_q;
  assign steer_oe_o  = oe_q;
  assign steer_drv_o = drv_q;
  assign lock_o      = lock_q;

  p_fv_ends_charge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fv_ev_i |=> !charge_q);
  p_charge_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(charge_q) |-> $past(fr_ev_i && !fv_ev_i));
  p_both_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fr_ev_i && fv_ev_i) |=> (!oe_q && !charge_q));
  p_slow_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && drv_q) |-> $past(fr_ev_i && !fv_ev_i));
  p_fast_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_q && !drv_q) |-> $past(fv_ev_i && !fr_ev_i));
  p_oe_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> !oe_q);
endmodule

// File: rtl/refdiv_steer.sv
`timescale 1ns/1ps
module refdiv_steer #(
  parameter int unsigned RW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [RW-1:0] div_r_i,
  input  logic          fv_i,
  output logic          fr_o,
  output logic          charge_o,
  output logic          steer_oe_o,
  output logic          steer_drv_o,
  output logic          lock_o
);
  logic fr_pulse;
  logic fv_rise;

  ref_div #(.RW(RW)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_r_i (div_r_i),
    .fr_o    (fr_pulse)
  );

  edge_rise u_fv_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (fv_i),
    .rise_o (fv_rise)
  );

  steer_ctrl u_steer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fr_ev_i     (fr_pulse),
    .fv_ev_i     (fv_rise),
    .charge_o    (charge_o),
    .steer_oe_o  (steer_oe_o),
    .steer_drv_o (steer_drv_o),
    .lock_o      (lock_o)
  );

  assign fr_o = fr_pulse;

  p_lock_vs_oe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o == !steer_oe_o));
endmodule

// File: tb/refdiv_steer_tb.sv
`timescale 1ns/1ps
module refdiv_steer_tb;
  localparam int RW = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [RW-1:0] div_r = '0;
  logic          fv = 1'b0;
  logic          fr_o, charge_o, steer_oe_o, steer_drv_o, lock_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  refdiv_steer #(.RW(RW)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .div_r_i     (div_r),
    .fv_i        (fv),
    .fr_o        (fr_o),
    .charge_o    (charge_o),
    .steer_oe_o  (steer_oe_o),
    .steer_drv_o (steer_drv_o),
    .lock_o      (lock_o)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // expected-state model from the requirements
  logic mon_en = 1'b0;
  int   r_exp = 3;
  logic e_charge, e_oe, e_drv, e_lock, prev_fv;
  int   last_ev;   // 0 none, 1 fR, 2 fV
  int   gap;
  logic seen_fr;

  always @(negedge clk) begin
    if (mon_en) begin
      chk("R3/R4 charge_o", charge_o, e_charge);
      chk("R7 steer_oe_o", steer_oe_o, e_oe);
      if (e_oe) chk(e_drv ? "R5 steer_drv_o" : "R6 steer_drv_o", steer_drv_o, e_drv);
      chk("R8 lock_o", lock_o, e_lock);
      gap++;
      if (fr_o) begin
        if (seen_fr) begin
          total++;
          if (gap != r_exp) begin
            bad++;
            $display("FAIL R1/R2 fR spacing: got %0d expected %0d (R=%0d)",
                     gap, r_exp, div_r);
          end
        end
        seen_fr = 1'b1;
        gap = 0;
      end
      begin
        logic fr_ev, fv_ev;
        fr_ev = fr_o;
        fv_ev = fv && !prev_fv;  // R10
        prev_fv = fv;
        e_oe = 1'b0;
        e_drv = 1'b0;
        if (fr_ev && fv_ev) begin
          last_ev = 0; e_charge = 1'b0;
        end else if (fr_ev) begin
          if (last_ev == 1) begin e_oe = 1'b1; e_drv = 1'b1; end
          last_ev = 1; e_charge = 1'b1;
        end else if (fv_ev) begin
          if (last_ev == 2) begin e_oe = 1'b1; e_drv = 1'b0; end
          last_ev = 2; e_charge = 1'b0;
        end
        e_lock = !e_oe;
      end
    end
  end

  // mode: 0 fV quiet, 1 periodic fV, 2 fV mirrors fR, 3 fV held high
  task automatic run_cfg(input int r, input int mode, input int pv, input int ncyc);
    int ph;
    mon_en = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b0;
    fv = 1'b0;
    div_r = RW'(r);
    r_exp = (r < 3) ? 3 : r;
    repeat (2) @(negedge clk);
    chk("R9 reset fr_o", fr_o, 1'b0);
    chk("R9 reset charge_o", charge_o, 1'b0);
    chk("R9 reset steer_oe_o", steer_oe_o, 1'b0);
    chk("R9 reset lock_o", lock_o, 1'b1);
    e_charge = 1'b0; e_oe = 1'b0; e_drv = 1'b0; e_lock = 1'b1;
    prev_fv = 1'b0; last_ev = 0; gap = 0; seen_fr = 1'b0;
    #1;
    rst_n = 1'b1;
    mon_en = 1'b1;
    ph = 1;
    for (int c = 0; c < ncyc; c++) begin
      @(posedge clk); #1;
      case (mode)
        1: begin
          fv = (ph == 0);
          ph = (ph + 1) % pv;
        end
        2: fv = fr_o;          // R4: same-edge events
        3: fv = (c >= 5);      // R10: one rise only
        default: fv = 1'b0;
      endcase
    end
  endtask

  initial begin
    int rlist [8] = '{0, 1, 2, 3, 4, 5, 7, 10};
    repeat (3) @(negedge clk);
    foreach (rlist[i]) begin
      int r, re, n;
      r = rlist[i];
      re = (r < 3) ? 3 : r;
      n = 10 * re + 30;
      run_cfg(r, 0, 2, n);            // R5 VCO slow
      run_cfg(r, 1, 2, n);            // R6 VCO fast
      run_cfg(r, 1, 3, n);
      run_cfg(r, 1, re + 1, n);
      run_cfg(r, 1, 2 * re, n);
      run_cfg(r, 1, re, n);
      run_cfg(r, 2, 2, n);            // R4
      run_cfg(r, 3, 2, n);            // R10
    end
    run_cfg(16383, 0, 2, 3 * 16383 + 20);  // R1 at the top of range
    mon_en = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #900000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule